// File: doc/BRIEF.md
# Half-Duplex Three-Wire Serial Bus Monitor

This block passively observes a three-wire, half-duplex synchronous serial bus: an active-high select, a bus clock, a line into the target (`bus_din`) and a line out of it (`bus_dout`). The bus lines run in their own clock domain. A much faster system clock samples all four lines through two-flop synchronizers, and every edge is taken from the registered values. The block never drives the bus.

Each select window is sorted as it unfolds. The window is a data transfer if the first rising bus clock edge finds `bus_din` high. It is a ready/busy poll if no rising edge occurs, or if the first rising edge finds `bus_din` low. In a data window the block emits each bit as soon as the bit closes. The bit carries the din level from its rising edge and the dout level from its falling edge. A frame-done pulse follows the end of the window. Frame length is never assumed, so instruction, address and word sizes may be anything. In a poll window the block watches `bus_dout`: low means the target is busy, high means it is ready. At the end of the window it reports the final level. It pulses once on the first busy-to-ready rise.

The system clock must run at least four times faster than the bus clock. Bus lines must hold each level for at least three system clocks.

Top module: `hdx_serial_monitor`

## Requirements
- R1: After reset, and before any bus activity, every output is low.
- R2: If the bus clock is high when select rises, `warn_clk_high` pulses once. Decoding is unchanged: the first bit begins at the next real rising edge.
- R3: In a data window, `si_bit` of each emitted bit is the `bus_din` level at the rising bus clock edge that opened the bit.
- R4: `so_bit` of each emitted bit is the `bus_dout` level at the falling bus clock edge inside that bit.
- R5: A bit is emitted as a one-cycle `bit_valid` pulse when the next rising edge arrives. `is_start_bit` is 1 for the first bit of a data window and 0 for every later bit.
- R6: When select falls with the bus clock low, the open bit is emitted. When select falls with the bus clock high, the bit opened by that last rising edge is discarded.
- R7: `frame_done` pulses exactly once per data window, after the select fall and after that window's last `bit_valid`.
- R8: The number of emitted bits equals the number of bits on the bus, for any length from 1 upward.
- R9: A window with no rising bus clock edge is a poll. It emits no bits and no `frame_done`. At the select fall it gives one `status_valid` pulse, with `status_ready` equal to the `bus_dout` level at that moment (1 ready, 0 busy).
- R10: If `bus_din` is low at the first rising edge of a window, `warn_start_low` pulses once and the window is handled as a poll (R9 outputs, no bits). A start bit that is emitted therefore always has `si_bit` = 1.
- R11: In a window that has not yet seen a start bit, `busy_to_ready` pulses on the first low-to-high change of `bus_dout`. Later rises in the same window are ignored. Changes before select rises are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus select, active high, asynchronous |
| bus_clk | input | 1 | Bus clock, asynchronous |
| bus_din | input | 1 | Data into the target, asynchronous |
| bus_dout | input | 1 | Data out of the target, asynchronous |
| bit_valid | output | 1 | One-cycle strobe when a bit closes |
| si_bit | output | 1 | din value of the emitted bit |
| so_bit | output | 1 | dout value of the emitted bit |
| is_start_bit | output | 1 | Emitted bit is the first of its window |
| frame_done | output | 1 | One-cycle pulse at the end of a data window |
| status_valid | output | 1 | One-cycle pulse at the end of a poll window |
| status_ready | output | 1 | Final dout level of the poll window |
| busy_to_ready | output | 1 | First dout rise within a poll window |
| warn_clk_high | output | 1 | Bus clock was high when select rose |
| warn_start_low | output | 1 | First sampled din bit was low |

## Verification
Data windows use random din/dout patterns and lengths from a single start bit up to forty bits. This separates rising-edge from falling-edge sampling and catches off-by-one bit counts. Each data window ends either with the clock low or just after an extra rising edge. This distinguishes closing the final bit from dropping the half-opened one. Poll windows use random dout level sequences, with and without clock pulses carrying a low first bit. This separates final-level reporting from a busy-to-ready report that must fire only once. Windows started with the clock already high check that the warning does not shift the bit boundaries.

// File: rtl/hdx_serial_monitor.sv
module hdx_serial_monitor #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_sel,
  input  logic bus_clk,
  input  logic bus_din,
  input  logic bus_dout,
  output logic bit_valid,
  output logic si_bit,
  output logic so_bit,
  output logic is_start_bit,
  output logic frame_done,
  output logic status_valid,
  output logic status_ready,
  output logic busy_to_ready,
  output logic warn_clk_high,
  output logic warn_start_low
);

  localparam int CHAIN_W = SYNC_STAGES * 4;

  typedef enum logic [1:0] {W_IDLE, W_OPEN, W_DATA, W_POLL} win_t;

  logic [CHAIN_W-1:0] chain;
  logic [3:0] now_v, prev_v;
  win_t win;
  logic bit_open, cur_si, cur_so, cur_start, rise_seen, fd_q;
  logic sel_rise, sel_fall, clk_rise, clk_fall, so_rise;

  assign now_v    = chain[CHAIN_W-1 -: 4];
  assign sel_rise = now_v[0] & ~prev_v[0];
  assign sel_fall = ~now_v[0] & prev_v[0];
  assign clk_rise = now_v[1] & ~prev_v[1];
  assign clk_fall = ~now_v[1] & prev_v[1];
  assign so_rise  = now_v[3] & ~prev_v[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain          <= '0;
      prev_v         <= '0;
      win            <= W_IDLE;
      bit_open       <= 1'b0;
      cur_si         <= 1'b0;
      cur_so         <= 1'b0;
      cur_start      <= 1'b0;
      rise_seen      <= 1'b0;
      fd_q           <= 1'b0;
      bit_valid      <= 1'b0;
      si_bit         <= 1'b0;
      so_bit         <= 1'b0;
      is_start_bit   <= 1'b0;
      frame_done     <= 1'b0;
      status_valid   <= 1'b0;
      status_ready   <= 1'b0;
      busy_to_ready  <= 1'b0;
      warn_clk_high  <= 1'b0;
      warn_start_low <= 1'b0;
    end else begin
      chain          <= {chain[CHAIN_W-5:0], bus_dout, bus_din, bus_clk, bus_sel};
      prev_v         <= now_v;
      bit_valid      <= 1'b0;
      fd_q           <= 1'b0;
      frame_done     <= fd_q;
      status_valid   <= 1'b0;
      busy_to_ready  <= 1'b0;
      warn_clk_high  <= 1'b0;
      warn_start_low <= 1'b0;
      if (sel_rise) begin
        win           <= W_OPEN;
        bit_open      <= 1'b0;
        rise_seen     <= 1'b0;
        warn_clk_high <= now_v[1];
      end else if (sel_fall) begin
        if (win == W_DATA) begin
          if (bit_open && !now_v[1]) begin
            bit_valid    <= 1'b1;
            si_bit       <= cur_si;
            so_bit       <= cur_so;
            is_start_bit <= cur_start;
          end
          fd_q <= 1'b1;
        end else if (win != W_IDLE) begin
          status_valid <= 1'b1;
          status_ready <= now_v[3];
        end
        win      <= W_IDLE;
        bit_open <= 1'b0;
      end else if (win != W_IDLE) begin
        if (clk_rise) begin
          if (win == W_OPEN) begin
            if (now_v[2]) begin
              win       <= W_DATA;
              bit_open  <= 1'b1;
              cur_si    <= 1'b1;
              cur_so    <= 1'b0;
              cur_start <= 1'b1;
            end else begin
              win            <= W_POLL;
              warn_start_low <= 1'b1;
            end
          end else if (win == W_DATA) begin
            bit_valid    <= 1'b1;
            si_bit       <= cur_si;
            so_bit       <= cur_so;
            is_start_bit <= cur_start;
            cur_si       <= now_v[2];
            cur_so       <= 1'b0;
            cur_start    <= 1'b0;
          end
        end
        if (clk_fall && win == W_DATA && bit_open)
          cur_so <= now_v[3];
        if (so_rise && (win == W_OPEN || win == W_POLL) && !rise_seen) begin
          busy_to_ready <= 1'b1;
          rise_seen     <= 1'b1;
        end
      end
    end
  end

  AST_BIT_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> ($past(clk_rise) || $past(sel_fall))); // R5
  AST_START_IS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && is_start_bit) |-> si_bit); // R10
  AST_DONE_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !$past(now_v[0], 2)); // R7
  AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |-> !(bit_valid || frame_done)); // R9
  AST_STATUS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |-> !$past(now_v[0])); // R9

endmodule

// File: tb/tb_hdx_serial_monitor.sv
module tb_hdx_serial_monitor;
  localparam int H = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, sck = 1'b0, din = 1'b0, dout = 1'b0;
  logic bit_valid, si_bit, so_bit, is_start_bit, frame_done;
  logic status_valid, status_ready, busy_to_ready, warn_clk_high, warn_start_low;

  hdx_serial_monitor dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_clk(sck), .bus_din(din), .bus_dout(dout),
    .bit_valid(bit_valid), .si_bit(si_bit), .so_bit(so_bit), .is_start_bit(is_start_bit),
    .frame_done(frame_done), .status_valid(status_valid), .status_ready(status_ready),
    .busy_to_ready(busy_to_ready), .warn_clk_high(warn_clk_high), .warn_start_low(warn_start_low)
  );

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;
  int bits_seen = 0, n_done = 0, n_stat = 0, n_b2r = 0, n_wck = 0, n_wst = 0;
  logic bsi [256];
  logic bso [256];
  logic bst [256];
  logic last_ready = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (bit_valid) begin
        bsi[bits_seen % 256] = si_bit;
        bso[bits_seen % 256] = so_bit;
        bst[bits_seen % 256] = is_start_bit;
        bits_seen++;
      end
      if (frame_done) n_done++;
      if (status_valid) begin n_stat++; last_ready = status_ready; end
      if (busy_to_ready) n_b2r++;
      if (warn_clk_high) n_wck++;
      if (warn_start_low) n_wst++;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int k);
    repeat (k) @(negedge clk);
  endtask

  function automatic logic exp_si(logic [63:0] v, int i);
    return (i == 0) ? 1'b1 : v[i];
  endfunction

  task automatic run_data(int n, logic [63:0] siv, logic [63:0] sov, bit hi_start, bit hi_end);
    int b0 = bits_seen, d0 = n_done, s0 = n_stat, w0 = n_wck, ws0 = n_wst;
    sck = hi_start; din = 1'b0; wait_cyc(H);
    sel = 1'b1; wait_cyc(H);
    if (hi_start) begin sck = 1'b0; wait_cyc(H); end
    for (int i = 0; i < n; i++) begin
      din = exp_si(siv, i); wait_cyc(H);
      sck = 1'b1; wait_cyc(H);
      dout = sov[i]; wait_cyc(H);
      sck = 1'b0;
    end
    wait_cyc(H);
    if (hi_end) begin din = 1'($urandom); sck = 1'b1; wait_cyc(H); dout = ~dout; wait_cyc(H); end
    sel = 1'b0; wait_cyc(H);
    sck = 1'b0; wait_cyc(2 * H);
    chk("R8 bit count", bits_seen - b0, n);
    for (int i = 0; i < n; i++) begin
      chk("R3 si_bit", int'(bsi[(b0 + i) % 256]), int'(exp_si(siv, i)));
      chk("R4 so_bit", int'(bso[(b0 + i) % 256]), int'(sov[i]));
      chk("R5 is_start_bit", int'(bst[(b0 + i) % 256]), (i == 0) ? 1 : 0);
    end
    chk("R7 frame_done count", n_done - d0, 1);
    chk("R9 no status in data window", n_stat - s0, 0);
    chk("R2 clock-high warning", n_wck - w0, int'(hi_start));
    chk("R10 no start warning", n_wst - ws0, 0);
    if (!hi_end) chk("R6 final bit closed on deselect", bits_seen - b0, n);
  endtask

  task automatic run_poll(logic init, int k, logic [15:0] lv, int nclk);
    int b0 = bits_seen, d0 = n_done, s0 = n_stat, r0 = n_b2r, ws0 = n_wst;
    logic prevl = init;
    int exp_b2r = 0;
    dout = init; din = 1'b0; sck = 1'b0; wait_cyc(H);
    sel = 1'b1; wait_cyc(H);
    for (int i = 0; i < nclk; i++) begin
      din = 1'b0; wait_cyc(H);
      sck = 1'b1; wait_cyc(H);
      sck = 1'b0; wait_cyc(H);
    end
    for (int i = 0; i < k; i++) begin
      dout = lv[i];
      if (lv[i] && !prevl) exp_b2r = 1;
      prevl = lv[i];
      wait_cyc(H);
    end
    sel = 1'b0; wait_cyc(3 * H);
    chk("R9 status count", n_stat - s0, 1);
    chk("R9 status_ready", int'(last_ready), int'(prevl));
    chk("R9 no bits in poll", bits_seen - b0, 0);
    chk("R9 no frame_done in poll", n_done - d0, 0);
    chk("R11 busy_to_ready count", n_b2r - r0, exp_b2r);
    chk("R10 start-low warning", n_wst - ws0, (nclk > 0) ? 1 : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(3);
    chk("R1 outputs after reset", int'({bit_valid, si_bit, so_bit, is_start_bit, frame_done,
        status_valid, status_ready, busy_to_ready, warn_clk_high, warn_start_low}), 0);
    run_data(1, 64'h0, 64'h1, 1'b0, 1'b0);
    run_data(1, 64'h0, 64'h0, 1'b0, 1'b1);
    run_data(8, 64'hA5, 64'h3C, 1'b1, 1'b0);
    run_data(40, 64'hF0F0_1234_5678, 64'h0F0F_AAAA_5555, 1'b0, 1'b1);
    run_poll(1'b0, 0, 16'h0, 0);
    run_poll(1'b1, 0, 16'h0, 0);
    run_poll(1'b0, 4, 16'b0101, 0);
    run_poll(1'b0, 3, 16'b001, 2);
    for (int t = 0; t < 40; t++) begin
      if ($urandom % 3 != 0)
        run_data(1 + int'($urandom % 24), {$urandom, $urandom}, {$urandom, $urandom},
                 1'($urandom), 1'($urandom));
      else
        run_poll(1'($urandom), int'($urandom % 8), 16'($urandom), int'($urandom % 3));
    end
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule